// File: doc/BRIEF.md
# Four-Register Factorial Sequencer Datapath

This block is a small general-purpose datapath driven by a hard-wired sequencer that computes a factorial. The datapath holds four data registers. Each register has its own load enable. Two operand selectors route any register to either input of an arithmetic/logic unit. A result selector picks one of six operations: add, subtract, multiply, AND, OR and XOR. The selected result is written back into one destination register, and only when the write enable is set. The unit also reports whether the selected result is all zeros. That zero flag is the only status the sequencer sees.

The sequencer executes one datapath operation per cycle. Each loop iteration therefore takes three states. The first multiplies the accumulator by the counter. The second subtracts the constant one from the counter. The third compares the counter against the zero register without writing anything, and it either leaves the loop or returns to the multiply state. While `load_i` is high, the registers are preset from the argument input and the sequencer is armed. When `load_i` drops, the computation runs to a done state and holds there.

Top module: `fact_dp_top`

## Requirements
- R1: After reset, all four registers read zero, `done_o` is low and no computation runs.
- R2: At every clock edge with `load_i` high, register 0 (counter) takes `n_i`, register 1 (accumulator) takes 1, register 2 takes 1 and register 3 takes 0, and the sequencer restarts at the multiply state. This also applies in the middle of a run.
- R3: Each iteration takes exactly three cycles. For an argument N ≥ 1, `done_o` is low for the first 3·N cycles after `load_i` falls and is high from cycle 3·N on.
- R4: The loop ends only when the zero flag of the test step (counter minus register 3) is set. At that point register 0 is zero and `result_o` (register 1) equals N! modulo 2^DATA_W.
- R5: Registers 2 and 3 keep their preset values for the whole run, because no step enables their loads.
- R6: Outside a preload, at most one register changes value per clock edge.
- R7: Once `done_o` is high and `load_i` stays low, `done_o` stays high and all registers hold their values.
- R8: Products wrap modulo 2^DATA_W. For an argument of 13 with 32-bit data, the result is 1932053504.
- R9: In each test cycle, `zero_o` is high exactly when the counter has reached zero, which is the final iteration only. Operation codes are 0 add, 1 subtract, 2 multiply, 3 AND, 4 OR and 5 XOR, and the test cycle uses subtract.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Preset the registers and arm the sequencer |
| n_i | input | DATA_W | Factorial argument, loaded into register 0 |
| done_o | output | 1 | Sequencer has reached its done state |
| zero_o | output | 1 | Currently selected ALU result is all zeros |
| result_o | output | DATA_W | Accumulator (register 1) |
| regs_o | output | 4*DATA_W | All registers, register i at bits [i*DATA_W +: DATA_W] |

## Verification
The sequence is run with an argument of 1, which exits after a single iteration. It is also run with small arguments (3 and 5), where the iteration count and the position of the exit test can be told apart cycle by cycle. An argument of 12 is the largest whose result fits without wrap, and 13 is run to show that truncation of the multiply is modulo the data width. A run is reloaded midway to show that the preset overrides a computation in progress. After completion the block is held idle to show the frozen state. At every cycle the bench counts how many registers changed and confirms that the two constant registers kept their preset values.

// File: rtl/fact_pkg.sv
package fact_pkg;

    localparam int NUM_REGS = 4;
    localparam int SEL_W    = $clog2(NUM_REGS);

    // register roles used by the sequencer
    localparam logic [SEL_W-1:0] IDX_CNT  = 2'd0;
    localparam logic [SEL_W-1:0] IDX_ACC  = 2'd1;
    localparam logic [SEL_W-1:0] IDX_ONE  = 2'd2;
    localparam logic [SEL_W-1:0] IDX_NULL = 2'd3;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_XOR = 3'd5
    } alu_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_DEC,
        ST_TEST,
        ST_DONE
    } seq_st_e;

    typedef struct packed {
        logic [SEL_W-1:0] asel;
        logic [SEL_W-1:0] bsel;
        alu_op_e          op;
        logic             wen;
        logic [SEL_W-1:0] wsel;
    } dp_ctrl_t;

endpackage

// File: rtl/fact_alu.sv
module fact_alu
    import fact_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] y_o,
    output logic              zero_o
);

    logic [2*DATA_W-1:0] prod_full;

    always_comb begin
        prod_full = a_i * b_i;
        unique case (op_i)
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_MUL:  y_o = prod_full[DATA_W-1:0];
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            default: y_o = '0;
        endcase
        zero_o = (y_o == '0);
    end

endmodule

// File: rtl/fact_regfile.sv
module fact_regfile
    import fact_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               preset_i,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]    preset_val_i,
    input  logic                               wen_i,
    input  logic [SEL_W-1:0]                   wsel_i,
    input  logic [DATA_W-1:0]                  wdata_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]    regs_o
);

    logic [NUM_REGS-1:0][DATA_W-1:0] r_d, r_q;
    logic [NUM_REGS-1:0]             ld_en;

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        assign ld_en[gi] = wen_i && (wsel_i == SEL_W'(gi));

        always_comb begin
            if (preset_i)         r_d[gi] = preset_val_i[gi];
            else if (ld_en[gi])   r_d[gi] = wdata_i;
            else                  r_d[gi] = r_q[gi];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q[gi] <= '0;
            else        r_q[gi] <= r_d[gi];
        end
    end

    assign regs_o = r_q;

endmodule

// File: rtl/fact_seq.sv
module fact_seq
    import fact_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  logic     zero_i,
    output dp_ctrl_t ctrl_o,
    output logic     done_o
);

    typedef struct packed {
        seq_st_e st;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        ctrl_o.asel   = IDX_CNT;
        ctrl_o.bsel   = IDX_NULL;
        ctrl_o.op     = OP_SUB;
        ctrl_o.wen    = 1'b0;
        ctrl_o.wsel   = IDX_CNT;

        unique case (s_q.st)
            ST_MUL: begin
                ctrl_o.asel = IDX_ACC;
                ctrl_o.bsel = IDX_CNT;
                ctrl_o.op   = OP_MUL;
                ctrl_o.wen  = 1'b1;
                ctrl_o.wsel = IDX_ACC;
                s_d.st      = ST_DEC;
            end
            ST_DEC: begin
                ctrl_o.asel = IDX_CNT;
                ctrl_o.bsel = IDX_ONE;
                ctrl_o.op   = OP_SUB;
                ctrl_o.wen  = 1'b1;
                ctrl_o.wsel = IDX_CNT;
                s_d.st      = ST_TEST;
            end
            ST_TEST: begin
                // counter minus zero register, no write-back
                s_d.st = zero_i ? ST_DONE : ST_MUL;
            end
            default: ;
        endcase

        if (load_i) begin
            ctrl_o.wen = 1'b0;
            s_d.st     = ST_MUL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE};
        else        s_q <= s_d;
    end

    assign done_o = (s_q.st == ST_DONE);

endmodule

// File: rtl/fact_dp_top.sv
module fact_dp_top
    import fact_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [DATA_W-1:0]            n_i,
    output logic                         done_o,
    output logic                         zero_o,
    output logic [DATA_W-1:0]            result_o,
    output logic [NUM_REGS*DATA_W-1:0]   regs_o
);

    dp_ctrl_t                        ctrl;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [NUM_REGS-1:0][DATA_W-1:0] preset_val;
    logic [DATA_W-1:0]               opa, opb, alu_y;
    logic                            alu_z;

    always_comb begin
        preset_val          = '0;
        preset_val[IDX_CNT] = n_i;
        preset_val[IDX_ACC] = DATA_W'(1);
        preset_val[IDX_ONE] = DATA_W'(1);
    end

    assign opa = regs[ctrl.asel];
    assign opb = regs[ctrl.bsel];

    fact_alu #(.DATA_W(DATA_W)) u_alu (
        .a_i    (opa),
        .b_i    (opb),
        .op_i   (ctrl.op),
        .y_o    (alu_y),
        .zero_o (alu_z)
    );

    fact_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk          (clk),
        .rst_n        (rst_n),
        .preset_i     (load_i),
        .preset_val_i (preset_val),
        .wen_i        (ctrl.wen),
        .wsel_i       (ctrl.wsel),
        .wdata_i      (alu_y),
        .regs_o       (regs)
    );

    fact_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .zero_i (alu_z),
        .ctrl_o (ctrl),
        .done_o (done_o)
    );

    assign zero_o   = alu_z;
    assign result_o = regs[IDX_ACC];
    assign regs_o   = regs;

endmodule

// File: rtl/fact_dp_chk.sv
module fact_dp_chk
    import fact_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       load_i,
    input logic [DATA_W-1:0]          n_i,
    input logic                       done_o,
    input logic [NUM_REGS*DATA_W-1:0] regs_o
);

    logic [DATA_W-1:0] r0, r1, r2, r3;
    assign r0 = regs_o[0*DATA_W +: DATA_W];
    assign r1 = regs_o[1*DATA_W +: DATA_W];
    assign r2 = regs_o[2*DATA_W +: DATA_W];
    assign r3 = regs_o[3*DATA_W +: DATA_W];

    assert_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (r0 == $past(n_i) && r1 == DATA_W'(1) && r2 == DATA_W'(1) && r3 == '0));

    assert_exit_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (r0 == '0));

    assert_const_regs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(r2) && $stable(r3)));

    assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($countones({r0 != $past(r0), r1 != $past(r1),
                                 r2 != $past(r2), r3 != $past(r3)}) <= 1));

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> (done_o && $stable(regs_o)));

endmodule

bind fact_dp_top fact_dp_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .n_i    (n_i),
    .done_o (done_o),
    .regs_o (regs_o)
);

// File: tb/fact_dp_top_tb.sv
module fact_dp_top_tb;

    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           load_i = 1'b0;
    logic [W-1:0]   n_i = '0;
    logic           done_o, zero_o;
    logic [W-1:0]   result_o;
    logic [4*W-1:0] regs_o;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fact_dp_top #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .n_i(n_i),
        .done_o(done_o), .zero_o(zero_o), .result_o(result_o), .regs_o(regs_o)
    );

    function automatic logic [W-1:0] rg(input int i);
        return regs_o[i*W +: W];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] fact_ref(input logic [W-1:0] n);
        logic [W-1:0] acc = 1;
        for (int k = 1; k <= int'(n); k++) acc = acc * W'(k);
        return acc;
    endfunction

    // preset then run to completion, checking every cycle
    task automatic run_fact(input logic [W-1:0] n);
        logic [4*W-1:0] prev;
        int nchg;
        int total = 3 * int'(n);
        @(negedge clk); load_i = 1'b1; n_i = n;
        @(negedge clk); load_i = 1'b0;
        chk(rg(0) == n && rg(1) == 1 && rg(2) == 1 && rg(3) == 0, "R2 preset", rg(0), n);
        for (int c = 0; c < total; c++) begin
            chk(done_o == 1'b0, "R3 done early", W'(done_o), 0);
            if (c % 3 == 2)
                chk(zero_o == (c == total - 1), "R9 test zero flag", W'(zero_o), W'(c == total - 1));
            prev = regs_o;
            @(negedge clk);
            nchg = 0;
            for (int i = 0; i < 4; i++) if (prev[i*W +: W] != rg(i)) nchg++;
            chk(nchg <= 1, "R6 one write", W'(nchg), 1);
            chk(rg(2) == 1 && rg(3) == 0, "R5 constants", rg(2), 1);
        end
        chk(done_o == 1'b1, "R3 done at 3N", W'(done_o), 1);
        chk(result_o == fact_ref(n), "R4 result", result_o, fact_ref(n));
        chk(rg(0) == 0, "R4 counter zero", rg(0), 0);
    endtask

    task automatic t_reset();
        chk(regs_o == '0, "R1 regs zero", regs_o[W-1:0], 0);
        chk(done_o == 1'b0, "R1 done low", W'(done_o), 0);
        repeat (3) @(negedge clk);
        chk(regs_o == '0 && !done_o, "R1 idle", regs_o[W-1:0], 0);
    endtask

    task automatic t_wrap();
        run_fact(13);
        chk(result_o == 32'd1932053504, "R8 wrap", result_o, 32'd1932053504);
    endtask

    task automatic t_restart();
        @(negedge clk); load_i = 1'b1; n_i = 6;
        @(negedge clk); load_i = 1'b0;
        repeat (7) @(negedge clk);
        chk(done_o == 1'b0, "R2 midrun busy", W'(done_o), 0);
        run_fact(3);
        chk(result_o == 6, "R2 restart result", result_o, 6);
    endtask

    task automatic t_hold();
        logic [4*W-1:0] snap;
        run_fact(4);
        snap = regs_o;
        repeat (10) @(negedge clk);
        chk(done_o == 1'b1, "R7 done held", W'(done_o), 1);
        chk(regs_o == snap, "R7 regs frozen", regs_o[2*W-1:W], snap[2*W-1:W]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_fact(1);
        run_fact(3);
        run_fact(5);
        run_fact(12);
        t_wrap();
        t_restart();
        t_hold();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule